// File: doc/BRIEF.md
# Operand-Swapping Radix-4 Booth Multiplier

This block multiplies two signed 16-bit values and returns the full 32-bit signed product. It is arranged to keep switching activity low. On each accepted operand pair it measures how many significant bits each operand really carries. The operand that needs fewer bits is steered into the radix-4 Booth recoder, and the other operand becomes the multiplicand. The recoded operand is short, so only its low-order Booth digits can be non-zero.

The number of digits that matter is worked out from that bit count. Partial-product rows above that count do not load new data. Their input registers keep the values from an earlier operation, and the summing logic sees those rows as a zero partial product.

Operands arrive over a valid/ready handshake and the product leaves over another one. A pair is accepted in any cycle where `in_valid` and `in_ready` are both high. The product appears on the next cycle. If `out_ready` is low, the product is held stable, `in_ready` drops, and new operands wait upstream. When `out_ready` is high, a held result drains and a new pair is accepted in the same cycle, so the block can take one pair per cycle.

Top module: `drm_booth_mult`

## Requirements
- R1: `out_product` equals the exact two's complement product of the accepted `in_a` and `in_b`, sign-extended to 32 bits. This covers every input pair, including -32768 times -32768 = 1073741824.
- R2: When a pair is accepted at a rising edge (`in_valid` and `in_ready` both high), `out_valid` is high from that edge on, and `out_product` shows the product of that pair.
- R3: While `out_valid` is high and `out_ready` is low, `in_ready` is low, `out_valid` stays high and `out_product` does not change. Operands offered during this time are not taken.
- R4: An operand's signed width is the number of bits needed to write it in two's complement: 1 for 0 and -1, otherwise the index of the highest bit that differs from bit 15, plus 2. The operand with the smaller signed width is Booth-recoded, with ties going to `in_a`. Swapping `in_a` and `in_b` never changes the product.
- R5: With signed width r for the recoded operand, the number of active Booth digits is min(8, (r+2)/2), using integer division. Digit 0 is always active. Digits at or above that count give a zero partial product.
- R6: A partial-product row that is inactive for an accepted pair keeps its previous inputs. Those stale inputs never reach the product, even when the previous pair was a wide one.
- R7: After reset, `out_valid` is 0, `in_ready` is 1 and `out_product` is 0.
- R8: If `out_valid` and `out_ready` are both high and no new pair is accepted, `out_valid` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block can accept a pair this cycle |
| in_a | input | 16 | First signed operand |
| in_b | input | 16 | Second signed operand |
| out_valid | output | 1 | `out_product` holds a result |
| out_ready | input | 1 | Downstream takes the result |
| out_product | output | 32 | Signed product |

## Verification
The output can drain and a new pair can be accepted in the same edge. The bench provokes this by stalling a result with `out_ready` low while `in_valid` is held high with a second pair, and then raising `out_ready`. The judgement is that the first product stays put and no new pair is taken during the stall, and that the second product shows up exactly one cycle after the release. A narrow pair following a wide pair puts fresh rows and frozen rows side by side in one product; this is judged against the arithmetic product, so stale row contents would show up as an error.

// File: rtl/drm_pkg.sv
package drm_pkg;

  typedef enum logic [2:0] {
    BS_ZERO = 3'd0,
    BS_POS1 = 3'd1,
    BS_POS2 = 3'd2,
    BS_NEG1 = 3'd3,
    BS_NEG2 = 3'd4
  } booth_sel_e;

  // Radix-4 digit from bits {b(2i+1), b(2i), b(2i-1)}
  function automatic booth_sel_e booth_decode(input logic [2:0] trip);
    case (trip)
      3'b001, 3'b010: booth_decode = BS_POS1;
      3'b011:         booth_decode = BS_POS2;
      3'b100:         booth_decode = BS_NEG2;
      3'b101, 3'b110: booth_decode = BS_NEG1;
      default:        booth_decode = BS_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/drm_range_unit.sv
module drm_range_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  output logic [W-1:0]   mplier,
  output logic [W-1:0]   mcand,
  output logic [W/2-1:0] act_mask
);
  localparam int NDIG = W / 2;
  localparam int RW   = $clog2(W + 1);

  logic [RW-1:0] width_a;
  logic [RW-1:0] width_b;
  logic [RW-1:0] width_sel;
  logic          take_b;

  // Signed width: highest bit differing from the sign, plus two; 1 if none
  always_comb begin
    width_a = RW'(1);
    width_b = RW'(1);
    for (int k = 0; k < W - 1; k++) begin
      if (opa[k] != opa[W-1]) width_a = RW'(k + 2);
      if (opb[k] != opb[W-1]) width_b = RW'(k + 2);
    end
  end

  assign take_b    = (width_b < width_a);
  assign mplier    = take_b ? opb : opa;
  assign mcand     = take_b ? opa : opb;
  assign width_sel = take_b ? width_b : width_a;

  always_comb begin
    int ndig;
    ndig = (int'(width_sel) + 2) / 2;
    if (ndig > NDIG) ndig = NDIG;
    for (int i = 0; i < NDIG; i++) begin
      act_mask[i] = (i < ndig);
    end
  end

endmodule

// File: rtl/drm_pp_row.sv
module drm_pp_row
  import drm_pkg::*;
#(
  parameter int W   = 16,
  parameter int IDX = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           en,
  input  logic [W-1:0]   mcand,
  input  logic [2:0]     trip,
  output logic [W-1:0]   mcand_q,
  output logic [2*W-1:0] pp
);
  localparam int PW = 2 * W;

  logic [2:0] trip_q;
  logic       on_q;
  booth_sel_e sel;
  logic signed [PW-1:0] base;
  logic signed [PW-1:0] mag;

  // Inputs only load when the row is active: an idle row stays frozen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      trip_q  <= '0;
      on_q    <= 1'b0;
    end else if (accept) begin
      on_q <= en;
      if (en) begin
        mcand_q <= mcand;
        trip_q  <= trip;
      end
    end
  end

  assign sel  = booth_decode(trip_q);
  assign base = PW'($signed(mcand_q));

  always_comb begin
    case (sel)
      BS_POS1: mag = base;
      BS_POS2: mag = base <<< 1;
      BS_NEG1: mag = -base;
      BS_NEG2: mag = -(base <<< 1);
      default: mag = '0;
    endcase
  end

  assign pp = on_q ? PW'(mag <<< (2 * IDX)) : '0;

endmodule

// File: rtl/drm_row_sum.sv
module drm_row_sum #(
  parameter int NDIG = 8,
  parameter int PW   = 32
) (
  input  logic [NDIG*PW-1:0] rows_flat,
  output logic [PW-1:0]      total
);
  always_comb begin
    total = '0;
    for (int i = 0; i < NDIG; i++) begin
      total = total + rows_flat[i*PW +: PW];
    end
  end
endmodule

// File: rtl/drm_booth_mult.sv
module drm_booth_mult #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_product
);
  localparam int NDIG = W / 2;
  localparam int PW   = 2 * W;

  logic              accept;
  logic [W-1:0]      mplier;
  logic [W-1:0]      mcand;
  logic [NDIG-1:0]   act_mask;
  logic [W:0]        mpl_ext;
  logic [NDIG*PW-1:0] rows_flat;
  logic [NDIG*W-1:0] row_mcand_flat;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (accept)    out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  drm_range_unit #(.W(W)) i_range (
    .opa      (in_a),
    .opb      (in_b),
    .mplier   (mplier),
    .mcand    (mcand),
    .act_mask (act_mask)
  );

  assign mpl_ext = {mplier, 1'b0};

  for (genvar g = 0; g < NDIG; g++) begin : g_row
    drm_pp_row #(.W(W), .IDX(g)) i_row (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .en      (act_mask[g]),
      .mcand   (mcand),
      .trip    (mpl_ext[2*g +: 3]),
      .mcand_q (row_mcand_flat[g*W +: W]),
      .pp      (rows_flat[g*PW +: PW])
    );
  end

  drm_row_sum #(.NDIG(NDIG), .PW(PW)) i_sum (
    .rows_flat (rows_flat),
    .total     (out_product)
  );

endmodule

// File: rtl/drm_booth_mult_chk.sv
module drm_booth_mult_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [W-1:0]   in_a,
  input logic [W-1:0]   in_b,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*W-1:0] out_product,
  input logic [W/2-1:0] act_mask,
  input logic [W/2*W-1:0] row_mcand_flat
);
  localparam int NDIG = W / 2;

  logic acc;
  logic signed [2*W-1:0] ref_q;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ref_q <= '0;
    else if (acc) ref_q <= $signed(in_a) * $signed(in_b);
  end

  AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_product == ref_q); // R1
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_product))); // R3
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R3
  AST_DIGIT0_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> act_mask[0]); // R5
  AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !acc) |=> !out_valid); // R8

  for (genvar i = 0; i < NDIG; i++) begin : g_frz
    AST_ROW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !act_mask[i]) |=> $stable(row_mcand_flat[i*W +: W])); // R6
  end

endmodule

bind drm_booth_mult drm_booth_mult_chk #(.W(W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .in_a           (in_a),
  .in_b           (in_b),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_product    (out_product),
  .act_mask       (act_mask),
  .row_mcand_flat (row_mcand_flat)
);

// File: tb/test_drm_booth_mult.sv
`timescale 1ns/1ps
module test_drm_booth_mult;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_a = '0;
  logic [15:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_product;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  drm_booth_mult i_drm_booth_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_product(out_product)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] mul_ref(input logic signed [15:0] a,
                                          input logic signed [15:0] b);
    logic signed [31:0] e;
    e = a * b;
    return e;
  endfunction

  // One pair: offered at a falling edge, taken at the next rising edge,
  // and judged at the falling edge after that (R1, R2)
  task automatic do_op(input logic [15:0] a, input logic [15:0] b,
                       input string req);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, {req, " valid"}, 32'(out_valid), 32'd1);
    chk(out_product == mul_ref(a, b), req, out_product, mul_ref(a, b));
  endtask

  initial begin
    logic [15:0] corner [6];
    logic [31:0] held;
    corner[0] = 16'h8000; corner[1] = 16'h7fff; corner[2] = 16'h0000;
    corner[3] = 16'hffff; corner[4] = 16'h0001; corner[5] = 16'hfffe;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk(out_valid == 1'b0, "R7 out_valid", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R7 in_ready", 32'(in_ready), 32'd1);
    chk(out_product == 32'd0, "R7 product", out_product, 32'd0);

    // R1 corner, incl. -32768 * -32768
    do_op(16'h8000, 16'h8000, "R1 min*min");
    chk(out_product == 32'h4000_0000, "R1 min*min value", out_product, 32'h4000_0000);
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        do_op(corner[i], corner[j], "R1 corner");

    // R4 order never matters
    do_op(16'h0003, 16'h8ad1, "R4 narrow first");
    do_op(16'h8ad1, 16'h0003, "R4 narrow second");
    do_op(16'h1234, 16'h1234, "R4 tie");

    // R5 narrow operands: few active digits
    for (int s = 0; s < 16; s++) begin
      do_op(16'(1 << s), 16'h9c41, "R5 single bit");
      do_op(16'h6a5b, 16'(-(1 << s)), "R5 negative power");
    end

    // R6 wide pair then narrow pair: frozen rows must not leak
    for (int k = 0; k < 200; k++) begin
      do_op(16'($urandom), 16'($urandom) | 16'h4000, "R6 wide");
      do_op(16'($urandom) & 16'h0007, 16'($urandom), "R6 narrow after wide");
    end

    // Near-exhaustive sweep over the 7-bit signed range
    for (int a = -64; a < 64; a++)
      for (int b = -64; b < 64; b++)
        do_op(16'(a), 16'(b), "R1 sweep");

    // Random full-range
    for (int k = 0; k < 3000; k++)
      do_op(16'($urandom), 16'($urandom), "R1 random");

    // R3 stall, then drain and accept in the same edge
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_a = 16'h0123; in_b = 16'hfedc;
    @(negedge clk);
    held = out_product;
    chk(held == mul_ref(16'h0123, 16'hfedc), "R3 first product", held,
        mul_ref(16'h0123, 16'hfedc));
    in_a = 16'h7001; in_b = 16'h0042;
    for (int k = 0; k < 3; k++) begin
      chk(in_ready == 1'b0, "R3 in_ready low", 32'(in_ready), 32'd0);
      chk(out_valid == 1'b1, "R3 valid held", 32'(out_valid), 32'd1);
      @(negedge clk);
      chk(out_product == held, "R3 product held", out_product, held);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R2 valid after release", 32'(out_valid), 32'd1);
    chk(out_product == mul_ref(16'h7001, 16'h0042), "R2 second product",
        out_product, mul_ref(16'h7001, 16'h0042));
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 drain", 32'(out_valid), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule